// File: doc/BRIEF.md
# Single-to-Bfloat16 Rounding Converter

This block converts between 32-bit IEEE single-precision words and 16-bit bfloat16 words. It has two directions. Narrowing rounds the 16 low bits away to the nearest even value and turns every NaN into a quiet NaN. Widening appends 16 zero bits below a bfloat16 word. It has no status flags, does not flush subnormals, and offers no other rounding mode. A value near the top of the finite range may round up into the infinity encoding without any indication.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. With the default `REGISTERED=1`, `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and no new input is taken. With `REGISTERED=0`, the stage is a wire: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `bf16_cvt_stage`

## Requirements
- R1: In narrow mode (`in_dir`=0), an input whose bits 30:0 are greater than 0x7F800000 as an unsigned number is a NaN. Its result is input bits 31:16 OR 0x0040, so that result bit 6 is set (for example 0x7F800001 gives 0x7FC0 and 0xFFA12345 gives 0xFFE1).
- R2: In narrow mode, a non-NaN input gives bits 31:16 of (input + 0x7FFF + input bit 16), and the carry out of bit 31 is dropped (0x3F807FFF gives 0x3F80, 0xC0490FDB gives 0xC049).
- R3: When the discarded half is exactly 0x8000, the tie goes to even: 0x3F808000 gives 0x3F80 and 0x3F818000 gives 0x3F82.
- R4: The infinities 0x7F800000 and 0xFF800000 are not NaN and give 0x7F80 and 0xFF80.
- R5: A finite value near the maximum may round into infinity: 0x7F7FFFFF gives 0x7F80.
- R6: The constants narrow as follows: 0x43889333 (273.15) gives 0x4389, 0x3FE66666 (1.8) gives 0x3FE6, and 0x42000000 (32.0) gives 0x4200.
- R7: In widen mode (`in_dir`=1), the result is `{in_half, 16'h0000}`, and `in_word` has no effect on it.
- R8: In narrow mode, the result appears in `out_result[15:0]` with bits 31:16 zero, and `in_half` has no effect on it.
- R9: With `REGISTERED=1`, an input accepted on one edge appears with `out_valid` high after the next edge. `in_ready` is high whenever `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold, and `in_ready` is low.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operand valid |
| in_ready | output | 1 | Stage can take an operand |
| in_dir | input | 1 | 0 = narrow, 1 = widen |
| in_word | input | 32 | Single-precision operand for narrowing |
| in_half | input | 16 | Bfloat16 operand for widening |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_result | output | 32 | Widened word, or narrowed word in bits 15:0 |

## Verification
The bench builds the block with its default widths (32/16, 8-bit exponent) and `REGISTERED=1`. This setting makes the one-cycle latency, the hold under back-pressure, and the same-edge drain-and-refill observable. The vector walk covers round-down, round-up, both tie parities, quiet NaNs of either sign, the infinities and rounding up into infinity. A widen vector carries a nonzero `in_word` and a narrow vector carries a nonzero `in_half`, to show that each mode ignores the other operand.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;
  typedef enum logic {
    CVT_NARROW = 1'b0,
    CVT_WIDEN  = 1'b1
  } cvt_dir_e;
endpackage

// File: rtl/bf16_narrow.sv
module bf16_narrow #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int EXP_W    = 8
) (
  input  logic [WIDE_W-1:0]   src,
  output logic [NARROW_W-1:0] dst
);
  localparam int DROP  = WIDE_W - NARROW_W;
  localparam int WMAN  = WIDE_W - 1 - EXP_W;
  localparam int QBIT  = NARROW_W - EXP_W - 2;
  localparam logic [WIDE_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {WMAN{1'b0}}};
  localparam logic [DROP-1:0]   HALF    = {1'b1, {(DROP-1){1'b0}}};
  localparam logic [NARROW_W-1:0] QMASK =
    {{(NARROW_W-1-QBIT){1'b0}}, 1'b1, {QBIT{1'b0}}};

  logic                is_nan;
  logic                keep_lsb;
  logic [DROP-1:0]     low;
  logic                bump;
  logic [NARROW_W-1:0] upper;

  assign upper    = src[WIDE_W-1:DROP];
  assign low      = src[DROP-1:0];
  assign keep_lsb = src[DROP];
  assign is_nan   = src[WIDE_W-2:0] > INF_MAG;

  // Adding (HALF-1)+lsb to the low half carries into the kept half exactly
  // when low exceeds HALF, or equals HALF with an odd kept half.
  assign bump = (low > HALF) || ((low == HALF) && keep_lsb);

  always_comb begin
    if (is_nan) dst = upper | QMASK;
    else        dst = upper + {{(NARROW_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/bf16_widen.sv
module bf16_widen #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [NARROW_W-1:0] src,
  output logic [WIDE_W-1:0]   dst
);
  localparam int DROP = WIDE_W - NARROW_W;
  assign dst = {src, {DROP{1'b0}}};
endmodule

// File: rtl/bf16_stage.sv
module bf16_stage #(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  generate
    if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      logic         take;

      assign s_ready = !vld_q || m_ready;
      assign take    = s_valid && s_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (take) begin
            vld_q <= 1'b1;
            dat_q <= s_data;
          end else if (m_ready) begin
            vld_q <= 1'b0;
          end
        end
      end

      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end else begin : g_wire
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/bf16_cvt_stage.sv
module bf16_cvt_stage #(
  parameter int WIDE_W     = 32,
  parameter int NARROW_W   = 16,
  parameter int EXP_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_dir,
  input  logic [WIDE_W-1:0]   in_word,
  input  logic [NARROW_W-1:0] in_half,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WIDE_W-1:0]   out_result
);
  import bf16_cvt_pkg::*;
  localparam int PAD = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] narrowed;
  logic [WIDE_W-1:0]   widened;
  logic [WIDE_W-1:0]   chosen;
  cvt_dir_e            dir;

  assign dir = cvt_dir_e'(in_dir);

  bf16_narrow #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .EXP_W(EXP_W)) u_narrow (
    .src(in_word),
    .dst(narrowed)
  );

  bf16_widen #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_widen (
    .src(in_half),
    .dst(widened)
  );

  always_comb begin
    if (dir == CVT_WIDEN) chosen = widened;
    else                  chosen = {{PAD{1'b0}}, narrowed};
  end

  bf16_stage #(.W(WIDE_W), .REGISTERED(REGISTERED)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (chosen),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (out_result)
  );
endmodule

// File: rtl/bf16_cvt_props.sv
module bf16_cvt_props #(
  parameter int WIDE_W     = 32,
  parameter int NARROW_W   = 16,
  parameter int EXP_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_dir,
  input logic [WIDE_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WIDE_W-1:0] out_result
);
  localparam int DROP = WIDE_W - NARROW_W;
  localparam int QBIT = NARROW_W - EXP_W - 2;
  localparam logic [WIDE_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {(WIDE_W-1-EXP_W){1'b0}}};

  logic acc;
  assign acc = in_valid && in_ready;

  generate
    if (REGISTERED) begin : g_chk
      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
      p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
      p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
      p_widen_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_dir) |=> (out_result[DROP-1:0] == '0));
      p_narrow_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_dir) |=> (out_result[WIDE_W-1:NARROW_W] == '0));
      p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_dir && (in_word[WIDE_W-2:0] > INF_MAG)) |=> out_result[QBIT]);
    end
  endgenerate
endmodule

bind bf16_cvt_stage bf16_cvt_props #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .EXP_W(EXP_W), .REGISTERED(REGISTERED)
) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dir(in_dir), .in_word(in_word), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/bf16_cvt_stage_test.sv
module bf16_cvt_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [31:0] in_word = '0;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bf16_cvt_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_word(in_word), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  localparam int NV = 17;
  localparam logic        V_DIR [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,0};
  localparam logic [31:0] V_IN  [NV] = '{
    32'h7F800001, 32'hFFA12345, 32'h3F807FFF, 32'hC0490FDB, 32'h3F808000,
    32'h3F818000, 32'h7F800000, 32'hFF800000, 32'h7F7FFFFF, 32'h43889333,
    32'h3FE66666, 32'h42000000, 32'h3F80C000, 32'h7FFFFFFF, 32'hDEADBEEF,
    32'h12345678, 32'h00000000};
  localparam logic [15:0] V_HALF[NV] = '{
    16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
    16'h0, 16'h0, 16'h0, 16'h0, 16'h4389, 16'hFFC1, 16'hABCD};
  localparam logic [31:0] V_EXP [NV] = '{
    32'h7FC0, 32'hFFE1, 32'h3F80, 32'hC049, 32'h3F80,
    32'h3F82, 32'h7F80, 32'hFF80, 32'h7F80, 32'h4389,
    32'h3FE6, 32'h4200, 32'h3F81, 32'h7FFF, 32'h43890000,
    32'hFFC10000, 32'h0000};
  localparam string V_REQ [NV] = '{
    "R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R6",
    "R6", "R6", "R2", "R1", "R7", "R7", "R8"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic d, input logic [31:0] w, input logic [15:0] h);
    @(negedge clk);
    in_valid = 1'b1; in_dir = d; in_word = w; in_half = h;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R11 in_ready in reset", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'b0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      send(V_DIR[i], V_IN[i], V_HALF[i]);
      check({V_REQ[i], " valid"}, {31'b0, out_valid}, 32'd1);
      check(V_REQ[i], out_result, V_EXP[i]);
    end

    // R9: no input, output slot drains, ready stays high
    @(negedge clk);
    check("R9 drained", {31'b0, out_valid}, 32'd0);
    check("R9 ready idle", {31'b0, in_ready}, 32'd1);

    // R10: back-pressure hold, then same-edge drain and refill
    out_ready = 1'b0;
    send(1'b0, 32'h43889333, 16'h0);
    check("R10 valid held", {31'b0, out_valid}, 32'd1);
    check("R10 ready low", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b1; in_dir = 1'b1; in_half = 16'h3FE6;
    @(posedge clk);
    @(negedge clk);
    check("R10 result held", out_result, 32'h4389);
    check("R10 still valid", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 refill result", out_result, 32'h3FE60000);
    check("R9 refill valid", {31'b0, out_valid}, 32'd1);

    // R11: reset mid-stream clears the output
    out_ready = 1'b0;
    send(1'b0, 32'h42000000, 16'h0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R11 reset clears valid", {31'b0, out_valid}, 32'd0);
    check("R11 reset ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1; out_ready = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule